// File: doc/BRIEF.md
# Base Cycle, Retire and Time Counter Unit

This block holds the cycle counter and the retired-instruction counter of a machine-mode register file, together with the read-only user views of both counters and of an externally kept 64-bit system time. A register-file front end presents a 12-bit register address, a read strobe, a write strobe, 32-bit write data and a flag that says whether the current hart runs in user mode. The block answers in the same cycle with read data and an illegal-access flag. Two single-cycle event inputs mark an active clock cycle and a retired instruction.

The combined counter width `CNT_WIDTH` (0 to 64) selects the build. Full width gives two 64-bit counters. A width from 32 to 63 keeps the high words but fixes their unused top bits at zero. A width from 1 to 31 removes the high words. A width of 0 removes both counters. Two constant status outputs report a reduced build and an absent build. A user-enable register controls user-mode reads of the counter views. A freeze register stops either counter. The access interface carries no back-pressure: there is no ready signal, every strobe is accepted in the cycle it is presented, and the answer comes back in that same cycle.

Top module: `csr_counter_unit`

## Requirements
- R1: Machine addresses 0xB00/0xB80 read and write the low/high 32 bits of the cycle counter, and 0xB02/0xB82 do the same for the retire counter. Counters reset to zero.
- R2: Each cycle with `evt_cycle` (or `evt_retire`) high and the counter not frozen adds one. The carry ripples from the low word into the high word, and the value wraps to zero at 2^CNT_WIDTH.
- R3: In a cycle where either half of a counter is written, the written half takes the write data, the other half holds, and that cycle's event is not counted.
- R4: Register 0x320 resets to zero. Bit 0 freezes the cycle counter and bit 2 freezes the retire counter. All other bits read as zero.
- R5: 0xC00/0xC80 and 0xC02/0xC82 read the same values as the machine cycle and retire addresses. 0xC01/0xC81 read the low/high words of `sys_time` for every CNT_WIDTH, including 0.
- R6: For CNT_WIDTH 32..63, high-word bits at and above CNT_WIDTH-32 read as zero and ignore writes, and `flag_small_cnt` is 1.
- R7: For CNT_WIDTH 1..31, any access to 0xB80, 0xB82, 0xC80 or 0xC82 is illegal, low-word bits at and above CNT_WIDTH read as zero, and `flag_small_cnt` is 1.
- R8: For CNT_WIDTH 0, any access to the eight counter addresses (0xB00, 0xB02, 0xB80, 0xB82, 0xC00, 0xC02, 0xC80, 0xC82) is illegal, `flag_no_cnt` is 1 and `flag_small_cnt` is 0. At 64 both flags are 0.
- R9: Register 0x306 holds user-enable bits: bit 0 for the cycle views, bit 1 for the time views and bit 2 for the retire views. A user-mode read of a view whose bit is clear is illegal. Bits 31:3 read as zero. With USER_MODE_EN=0 the whole register reads zero.
- R10: A user-mode access to any address whose bits 9:8 are non-zero is illegal. A write to any address whose bits 11:10 are 2'b11 is illegal in either mode.
- R11: An illegal access returns zero read data and changes no state. A legal read of an address this block does not hold returns zero and is not illegal. `csr_illegal` is 0 when neither strobe is high.
- R12: `csr_rdata` and `csr_illegal` follow the inputs in the same cycle. A write or count is visible to reads from the next clock edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 12 | Register address |
| csr_rd | input | 1 | Read strobe |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data |
| priv_user | input | 1 | 1 when the access comes from user mode |
| evt_cycle | input | 1 | Active-cycle event pulse |
| evt_retire | input | 1 | Retired-instruction event pulse |
| sys_time | input | 64 | External system time |
| csr_rdata | output | 32 | Read data, zero when not reading or illegal |
| csr_illegal | output | 1 | Access is illegal |
| flag_small_cnt | output | 1 | Counters narrower than 64 bits |
| flag_no_cnt | output | 1 | Counters absent |

## Verification
Read data and the illegal flag are combinational, so the bench drives each access on the falling edge and samples both outputs one nanosecond later, before the next rising edge. Writes, event counts and freeze or enable changes take effect at the following rising edge. The bench applies them to its own model only after that edge, so the next access reads the updated value. Three instances of width 40, 12 and 0 share one stimulus stream. Each instance is compared against a width-masked arithmetic model, and full 4096-address read sweeps in both privilege modes are repeated under several enable settings.

// File: rtl/cnt_unit_pkg.sv
package cnt_unit_pkg;
  localparam logic [11:0] A_MCYC_LO = 12'hB00;
  localparam logic [11:0] A_MRET_LO = 12'hB02;
  localparam logic [11:0] A_MCYC_HI = 12'hB80;
  localparam logic [11:0] A_MRET_HI = 12'hB82;
  localparam logic [11:0] A_UCYC_LO = 12'hC00;
  localparam logic [11:0] A_UTIM_LO = 12'hC01;
  localparam logic [11:0] A_URET_LO = 12'hC02;
  localparam logic [11:0] A_UCYC_HI = 12'hC80;
  localparam logic [11:0] A_UTIM_HI = 12'hC81;
  localparam logic [11:0] A_URET_HI = 12'hC82;
  localparam logic [11:0] A_UENABLE = 12'h306;
  localparam logic [11:0] A_FREEZE  = 12'h320;

  typedef enum logic [1:0] {ACC_NONE, ACC_CYC, ACC_TIM, ACC_RET} view_e;
endpackage

// File: rtl/cnt_reg.sv
module cnt_reg #(
  parameter int unsigned W = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  input  logic        inc,
  output logic [63:0] value
);
  logic [W-1:0] cnt_q;
  logic [63:0]  nxt;

  assign value = 64'(cnt_q);

  // a write to either half wins over the event of the same cycle
  always_comb begin
    nxt = value;
    if (wr_lo)      nxt[31:0]  = wdata;
    else if (wr_hi) nxt[63:32] = wdata;
    else if (inc)   nxt        = value + 64'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= nxt[W-1:0];
  end
endmodule

// File: rtl/cnt_decode.sv
module cnt_decode
  import cnt_unit_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [11:0] addr,
  input  logic        rd,
  input  logic        we,
  input  logic        user,
  input  logic [2:0]  uen,
  input  logic [1:0]  frz,
  input  logic [63:0] cyc,
  input  logic [63:0] ret,
  input  logic [63:0] tim,
  output logic [31:0] rdata,
  output logic        illegal
);
  logic  is_hi, is_ctr, absent, priv_fail, ro_fail, gate_fail;
  view_e view;

  always_comb begin
    unique case (addr)
      A_UCYC_LO, A_UCYC_HI: view = ACC_CYC;
      A_UTIM_LO, A_UTIM_HI: view = ACC_TIM;
      A_URET_LO, A_URET_HI: view = ACC_RET;
      default:              view = ACC_NONE;
    endcase
  end

  assign is_hi  = (addr == A_MCYC_HI) || (addr == A_MRET_HI) ||
                  (addr == A_UCYC_HI) || (addr == A_URET_HI);
  assign is_ctr = is_hi || (addr == A_MCYC_LO) || (addr == A_MRET_LO) ||
                  (addr == A_UCYC_LO) || (addr == A_URET_LO);

  generate
    if (W == 0) begin : g_none
      assign absent = is_ctr;
    end else if (W < 32) begin : g_narrow
      assign absent = is_hi;
    end else begin : g_wide
      assign absent = 1'b0;
    end
  endgenerate

  assign priv_fail = user && (addr[9:8] != 2'b00);
  assign ro_fail   = we && (addr[11:10] == 2'b11);
  assign gate_fail = user && (((view == ACC_CYC) && !uen[0]) ||
                              ((view == ACC_TIM) && !uen[1]) ||
                              ((view == ACC_RET) && !uen[2]));
  assign illegal   = (rd || we) && (absent || priv_fail || ro_fail || gate_fail);

  always_comb begin
    rdata = '0;
    if (rd && !illegal) begin
      unique case (addr)
        A_MCYC_LO, A_UCYC_LO: rdata = cyc[31:0];
        A_MCYC_HI, A_UCYC_HI: rdata = cyc[63:32];
        A_MRET_LO, A_URET_LO: rdata = ret[31:0];
        A_MRET_HI, A_URET_HI: rdata = ret[63:32];
        A_UTIM_LO:            rdata = tim[31:0];
        A_UTIM_HI:            rdata = tim[63:32];
        A_UENABLE:            rdata = {29'd0, uen};
        A_FREEZE:             rdata = {29'd0, frz[1], 1'b0, frz[0]};
        default:              rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/csr_counter_unit.sv
module csr_counter_unit
  import cnt_unit_pkg::*;
#(
  parameter int unsigned CNT_WIDTH    = 64,
  parameter bit          USER_MODE_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] csr_addr,
  input  logic        csr_rd,
  input  logic        csr_we,
  input  logic [31:0] csr_wdata,
  input  logic        priv_user,
  input  logic        evt_cycle,
  input  logic        evt_retire,
  input  logic [63:0] sys_time,
  output logic [31:0] csr_rdata,
  output logic        csr_illegal,
  output logic        flag_small_cnt,
  output logic        flag_no_cnt
);
  localparam bit HAS_CNT = (CNT_WIDTH > 0);

  logic        wr_ok;
  logic [2:0]  uen_q;
  logic [1:0]  frz_q;   // [0] cycle, [1] retire
  logic [63:0] cyc_val, ret_val;

  assign wr_ok          = csr_we && !csr_illegal;
  assign flag_small_cnt = HAS_CNT && (CNT_WIDTH < 64);
  assign flag_no_cnt    = !HAS_CNT;

  always_ff @(posedge clk) begin
    if (!rst_n)                            frz_q <= '0;
    else if (wr_ok && csr_addr == A_FREEZE) frz_q <= {csr_wdata[2], csr_wdata[0]};
  end

  generate
    if (USER_MODE_EN) begin : g_uen
      always_ff @(posedge clk) begin
        if (!rst_n)                             uen_q <= '0;
        else if (wr_ok && csr_addr == A_UENABLE) uen_q <= csr_wdata[2:0];
      end
    end else begin : g_no_uen
      assign uen_q = '0;
    end

    if (HAS_CNT) begin : g_cnt
      cnt_reg #(.W(CNT_WIDTH)) u_cyc (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_lo (wr_ok && csr_addr == A_MCYC_LO),
        .wr_hi (wr_ok && csr_addr == A_MCYC_HI),
        .wdata (csr_wdata),
        .inc   (evt_cycle && !frz_q[0]),
        .value (cyc_val)
      );
      cnt_reg #(.W(CNT_WIDTH)) u_ret (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_lo (wr_ok && csr_addr == A_MRET_LO),
        .wr_hi (wr_ok && csr_addr == A_MRET_HI),
        .wdata (csr_wdata),
        .inc   (evt_retire && !frz_q[1]),
        .value (ret_val)
      );
    end else begin : g_nocnt
      assign cyc_val = '0;
      assign ret_val = '0;
    end
  endgenerate

  cnt_decode #(.W(CNT_WIDTH)) u_dec (
    .addr    (csr_addr),
    .rd      (csr_rd),
    .we      (csr_we),
    .user    (priv_user),
    .uen     (uen_q),
    .frz     (frz_q),
    .cyc     (cyc_val),
    .ret     (ret_val),
    .tim     (sys_time),
    .rdata   (csr_rdata),
    .illegal (csr_illegal)
  );
endmodule

module csr_counter_unit_checker #(
  parameter int unsigned W = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] csr_addr,
  input logic        csr_rd,
  input logic        csr_we,
  input logic [31:0] csr_wdata,
  input logic        priv_user,
  input logic        evt_cycle,
  input logic [63:0] sys_time,
  input logic [31:0] csr_rdata,
  input logic        csr_illegal,
  input logic [2:0]  uen_q,
  input logic [1:0]  frz_q,
  input logic [63:0] cyc_val
);
  localparam logic [63:0] MASK   = (W >= 64) ? '1 : ((64'd1 << W) - 64'd1);
  localparam logic [31:0] LOMASK = MASK[31:0];

  logic cyc_wr;
  assign cyc_wr = csr_we && !csr_illegal && (csr_addr == 12'hB00 || csr_addr == 12'hB80);

  generate
    if (W > 0) begin : g_cnt_props
      assert_cycle_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_cycle && !frz_q[0] && !cyc_wr |=> cyc_val == (($past(cyc_val) + 64'd1) & MASK));
      assert_write_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        csr_we && !csr_illegal && csr_addr == 12'hB00 |=> cyc_val[31:0] == ($past(csr_wdata) & LOMASK));
      assert_freeze_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frz_q[0] && !cyc_wr |=> $stable(cyc_val));
    end
  endgenerate

  assert_time_view_R5: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rd && !csr_illegal && csr_addr == 12'hC01 |-> csr_rdata == sys_time[31:0]);
  assert_user_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rd && priv_user && csr_addr == 12'hC01 && !uen_q[1] |-> csr_illegal);
  assert_illegal_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> csr_rdata == 32'd0);
  assert_illegal_nowrite_R11: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we && csr_illegal |=> $stable(uen_q) && $stable(frz_q));
endmodule

bind csr_counter_unit csr_counter_unit_checker #(.W(CNT_WIDTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .csr_addr    (csr_addr),
  .csr_rd      (csr_rd),
  .csr_we      (csr_we),
  .csr_wdata   (csr_wdata),
  .priv_user   (priv_user),
  .evt_cycle   (evt_cycle),
  .sys_time    (sys_time),
  .csr_rdata   (csr_rdata),
  .csr_illegal (csr_illegal),
  .uen_q       (uen_q),
  .frz_q       (frz_q),
  .cyc_val     (cyc_val)
);

// File: tb/csr_counter_unit_bench.sv
module csr_counter_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] csr_addr = '0;
  logic        csr_rd = 1'b0, csr_we = 1'b0, priv_user = 1'b0;
  logic        evt_cycle = 1'b0, evt_retire = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [63:0] sys_time = 64'h0123_4567_89AB_CDEF;

  logic [31:0] rdv [3];
  logic        illv [3];
  logic        fsm [3];
  logic        fno [3];

  logic [63:0] m_cyc [3];
  logic [63:0] m_ret [3];
  logic [2:0]  m_uen [3];
  logic [1:0]  m_frz [3];

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  csr_counter_unit #(.CNT_WIDTH(40)) u_csr_counter_unit (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_rd(csr_rd), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .priv_user(priv_user), .evt_cycle(evt_cycle), .evt_retire(evt_retire),
    .sys_time(sys_time), .csr_rdata(rdv[0]), .csr_illegal(illv[0]),
    .flag_small_cnt(fsm[0]), .flag_no_cnt(fno[0]));
  csr_counter_unit #(.CNT_WIDTH(12)) u_narrow (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_rd(csr_rd), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .priv_user(priv_user), .evt_cycle(evt_cycle), .evt_retire(evt_retire),
    .sys_time(sys_time), .csr_rdata(rdv[1]), .csr_illegal(illv[1]),
    .flag_small_cnt(fsm[1]), .flag_no_cnt(fno[1]));
  csr_counter_unit #(.CNT_WIDTH(0)) u_zero (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_rd(csr_rd), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .priv_user(priv_user), .evt_cycle(evt_cycle), .evt_retire(evt_retire),
    .sys_time(sys_time), .csr_rdata(rdv[2]), .csr_illegal(illv[2]),
    .flag_small_cnt(fsm[2]), .flag_no_cnt(fno[2]));

  function automatic int wof(int i);
    return (i == 0) ? 40 : (i == 1) ? 12 : 0;
  endfunction

  function automatic logic [63:0] mask_of(int w);
    return (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic string tag_of(logic [11:0] a);
    case (a)
      12'hB00, 12'hB02, 12'hB80, 12'hB82, 12'hC00, 12'hC02, 12'hC80, 12'hC82: return "R1";
      12'hC01, 12'hC81: return "R5";
      12'h306: return "R9";
      12'h320: return "R4";
      default: return "R10";
    endcase
  endfunction

  // legality per the requirements R7, R8, R9, R10, R11
  function automatic logic exp_ill(int w, logic [11:0] a, logic r, logic wr, logic u, logic [2:0] en);
    logic ill, ctr, hi;
    ill = 1'b0;
    hi  = (a == 12'hB80) || (a == 12'hB82) || (a == 12'hC80) || (a == 12'hC82);
    ctr = hi || (a == 12'hB00) || (a == 12'hB02) || (a == 12'hC00) || (a == 12'hC02);
    if (u && a[9:8] != 2'b00) ill = 1'b1;
    if (wr && a[11:10] == 2'b11) ill = 1'b1;
    if (ctr && (w == 0 || (hi && w < 32))) ill = 1'b1;
    if (u && (a == 12'hC00 || a == 12'hC80) && !en[0]) ill = 1'b1;
    if (u && (a == 12'hC01 || a == 12'hC81) && !en[1]) ill = 1'b1;
    if (u && (a == 12'hC02 || a == 12'hC82) && !en[2]) ill = 1'b1;
    return (r || wr) && ill;
  endfunction

  function automatic logic [31:0] exp_rd(int i, logic [11:0] a, logic r, logic ill);
    if (!r || ill) return '0;
    case (a)
      12'hB00, 12'hC00: return m_cyc[i][31:0];
      12'hB80, 12'hC80: return m_cyc[i][63:32];
      12'hB02, 12'hC02: return m_ret[i][31:0];
      12'hB82, 12'hC82: return m_ret[i][63:32];
      12'hC01: return sys_time[31:0];
      12'hC81: return sys_time[63:32];
      12'h306: return {29'd0, m_uen[i]};
      12'h320: return {29'd0, m_frz[i][1], 1'b0, m_frz[i][0]};
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string tag, input int inst, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s inst=%0d addr=%h act=%h exp=%h", tag, inst, csr_addr, act, exp);
    end
  endtask

  task automatic apply(input logic [11:0] a, input logic r, input logic wr, input logic [31:0] d,
                       input logic u, input logic ec, input logic er, input string tag);
    logic ill [3];
    @(negedge clk);
    csr_addr = a; csr_rd = r; csr_we = wr; csr_wdata = d; priv_user = u;
    evt_cycle = ec; evt_retire = er;
    #1;
    for (int i = 0; i < 3; i++) begin
      ill[i] = exp_ill(wof(i), a, r, wr, u, m_uen[i]);
      chk(tag, i, 64'(illv[i]), 64'(ill[i]));
      chk(tag, i, 64'(rdv[i]), 64'(exp_rd(i, a, r, ill[i])));
    end
    @(posedge clk);
    for (int i = 0; i < 3; i++) begin
      logic [63:0] mk;
      logic cw, rw;
      mk = mask_of(wof(i));
      cw = 1'b0; rw = 1'b0;
      if (wr && !ill[i]) begin
        case (a)
          12'hB00: begin m_cyc[i] = {m_cyc[i][63:32], d} & mk; cw = 1'b1; end
          12'hB80: begin m_cyc[i] = {d, m_cyc[i][31:0]} & mk; cw = 1'b1; end
          12'hB02: begin m_ret[i] = {m_ret[i][63:32], d} & mk; rw = 1'b1; end
          12'hB82: begin m_ret[i] = {d, m_ret[i][31:0]} & mk; rw = 1'b1; end
          default: ;
        endcase
      end
      if (!cw && ec && !m_frz[i][0]) m_cyc[i] = (m_cyc[i] + 64'd1) & mk;
      if (!rw && er && !m_frz[i][1]) m_ret[i] = (m_ret[i] + 64'd1) & mk;
      if (wr && !ill[i] && a == 12'h306) m_uen[i] = d[2:0];
      if (wr && !ill[i] && a == 12'h320) m_frz[i] = {d[2], d[0]};
    end
  endtask

  task automatic mwr(input logic [11:0] a, input logic [31:0] d, input string tag);
    apply(a, 1'b0, 1'b1, d, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic rd_all(input logic u);
    for (int a = 0; a < 4096; a++) apply(12'(a), 1'b1, 1'b0, '0, u, 1'b0, 1'b0, tag_of(12'(a)));
  endtask

  task automatic rd_ctrs(input string tag);
    logic [11:0] lst [10] = '{12'hB00, 12'hB80, 12'hB02, 12'hB82, 12'hC00,
                              12'hC80, 12'hC02, 12'hC82, 12'hC01, 12'hC81};
    for (int k = 0; k < 10; k++) apply(lst[k], 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL R12 watchdog expired act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      m_cyc[i] = '0; m_ret[i] = '0; m_uen[i] = '0; m_frz[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R6 R7 R8: status flags per width
    chk("R6", 0, 64'(fsm[0]), 64'd1); chk("R6", 0, 64'(fno[0]), 64'd0);
    chk("R7", 1, 64'(fsm[1]), 64'd1); chk("R7", 1, 64'(fno[1]), 64'd0);
    chk("R8", 2, 64'(fsm[2]), 64'd0); chk("R8", 2, 64'(fno[2]), 64'd1);

    rd_ctrs("R1");                                  // reset values
    apply(12'h306, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R11"); // no strobe, not illegal

    // R1 R6 R7: write halves, masked by width
    mwr(12'hB00, 32'hFFFF_FFFE, "R1");
    mwr(12'hB80, 32'h1234_56AB, "R6");
    mwr(12'hB02, 32'h0000_0FFE, "R1");
    mwr(12'hB82, 32'hFFFF_FF00, "R6");
    rd_ctrs("R6");

    // R2: carry and narrow wrap
    for (int k = 0; k < 3; k++) apply(12'h000, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b1, "R2");
    rd_ctrs("R2");
    mwr(12'hB00, 32'hFFFF_FFFF, "R2");
    mwr(12'hB80, 32'hFFFF_FFFF, "R2");
    apply(12'h000, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b0, "R2"); // full 40-bit wrap
    rd_ctrs("R2");

    // R3: write wins over same-cycle event
    apply(12'hB00, 1'b0, 1'b1, 32'h0000_0055, 1'b0, 1'b1, 1'b1, "R3");
    apply(12'hB82, 1'b0, 1'b1, 32'h0000_0003, 1'b0, 1'b1, 1'b1, "R3");
    rd_ctrs("R3");

    // R4: freeze each counter
    mwr(12'h320, 32'hFFFF_FFFF, "R4");
    apply(12'h320, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R4");
    for (int k = 0; k < 2; k++) apply(12'h000, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b1, "R4");
    rd_ctrs("R4");
    mwr(12'h320, 32'h0000_0004, "R4");
    for (int k = 0; k < 2; k++) apply(12'h000, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b1, "R4");
    rd_ctrs("R4");
    mwr(12'h320, 32'h0000_0000, "R4");

    // R9 R10 R5: full read sweeps under several enable masks
    rd_all(1'b0);
    rd_all(1'b1);
    mwr(12'h306, 32'hFFFF_FFFF, "R9");
    rd_all(1'b1);
    sys_time = 64'hFEDC_BA98_7654_3210;
    mwr(12'h306, 32'h0000_0002, "R9");
    rd_all(1'b1);

    // R10 R11: illegal writes change nothing
    apply(12'h306, 1'b0, 1'b1, 32'h0000_0007, 1'b1, 1'b0, 1'b0, "R11");
    apply(12'h320, 1'b0, 1'b1, 32'h0000_0005, 1'b1, 1'b0, 1'b0, "R11");
    apply(12'hB00, 1'b0, 1'b1, 32'h0000_1111, 1'b1, 1'b0, 1'b0, "R10");
    apply(12'hC00, 1'b0, 1'b1, 32'h0000_2222, 1'b0, 1'b0, 1'b0, "R10");
    apply(12'hC02, 1'b0, 1'b1, 32'h0000_3333, 1'b1, 1'b0, 1'b0, "R10");
    apply(12'hB80, 1'b0, 1'b1, 32'h0000_0077, 1'b0, 1'b0, 1'b0, "R7");
    rd_ctrs("R11");
    apply(12'h306, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R11");
    apply(12'h320, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R11");
    apply(12'hC01, 1'b1, 1'b0, '0, 1'b1, 1'b0, 1'b0, "R8");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule